// File: doc/BRIEF.md
# Configurable CRC Engine

This block is a register-mapped checksum accelerator. Software picks one of three generator polynomials and four data-conditioning switches in a configuration register, writes a starting value to a seed register, and then streams data into a data register one byte or one 32-bit word at a time. Each write is folded into the running checksum in one clock cycle. The current checksum can be read back at any time.

The checksum runs most-significant-bit first and is not reflected. Reflected variants come from the input and output bit-reverse switches. The output reverse and complement act only on the read path. With both cleared, a read returns the raw internal state. That value can be stored and later written back as a seed to carry on the same computation. Byte and word writes may be mixed freely and issued on consecutive cycles.

Top module: `crc_engine`

## Requirements
- R1: After reset, the configuration register reads 0 and the checksum register reads 0x0000FFFF.
- R2: The configuration register at offset 0x0 holds bits [1:0] polynomial select (0 = 0x1021 16-bit, 1 = 0x8005 16-bit, 2 = 0x04C11DB7 32-bit, 3 acts as 0), bit 2 input bit-reverse, bit 3 input complement, bit 4 sum bit-reverse and bit 5 sum complement. It reads back bits [5:0], with bits [31:6] reading zero.
- R3: A write to offset 0x4 loads the seed as the new checksum state on the next cycle, keeping only bits [15:0] in 16-bit modes. Reads of 0x4 and of unmapped offsets return zero.
- R4: The checksum is computed MSB-first without reflection. For the ASCII bytes "123456789", seed 0xFFFF on polynomial 0 gives 0x29B1, seed 0 on polynomial 1 gives 0xFEE8, and seed 0xFFFFFFFF on polynomial 2 with sum complement gives 0xFC891918.
- R5: A write to offset 0x8 with the byte qualifier high folds in only data bits [7:0].
- R6: A write to offset 0x8 with the byte qualifier low folds in four bytes, bits [31:24] first. Any mix of byte and word writes gives the same result as the equivalent byte stream.
- R7: Input bit-reverse mirrors each byte for byte writes and all 32 bits for word writes. With input and sum reverse set, "123456789" gives 0xCBF43926 (polynomial 2, seed 0xFFFFFFFF, sum complement) and 0xBB3D (polynomial 1, seed 0).
- R8: Input complement inverts the written data before it is folded in.
- R9: Sum bit-reverse mirrors the 16- or 32-bit checksum on reads, and sum complement inverts it. Writes to the configuration register never alter the checksum state.
- R10: In 16-bit modes, checksum bits [31:16] always read as zero.
- R11: With both sum options clear, the checksum read equals the raw state. Writing that value to the seed register resumes the computation exactly.
- R12: Data writes accepted on consecutive cycles are each folded in. The checksum read in the cycle after a write already includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for the addressed register |
| busByte | input | 1 | Byte qualifier for data writes (1 = 8-bit, 0 = 32-bit) |
| busAddr | input | ADDR_W | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |

## Verification
The assertions check on every cycle that:
- the checksum state holds whenever no seed or data write is strobed, which covers configuration writes;
- seed loads land with the correct width mask;
- configuration writes are captured and otherwise held;
- at most one datapath operation fires per cycle;
- the upper half of the read value is zero in 16-bit modes.

Only the bench scenarios can show that the arithmetic is right. These scenarios cover:
- the known check values for each polynomial and reflection setting;
- the most-significant-byte-first order of word writes;
- equivalence of mixed byte and word streams;
- the save-and-resume path through a raw read and a reseed.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = WORD_W / BYTE_W;
  localparam int HALF_W  = 16;

  localparam int OFF_MODE = 0;
  localparam int OFF_SEED = 4;
  localparam int OFF_DATA = 8;

  typedef enum logic [1:0] {
    POLY_CCITT = 2'd0,
    POLY_CRC16 = 2'd1,
    POLY_CRC32 = 2'd2,
    POLY_RSVD  = 2'd3
  } polySel_e;

  // packed MSB first: cmplSum=bit5 ... poly=bits[1:0]
  typedef struct packed {
    logic     cmplSum;
    logic     revSum;
    logic     cmplIn;
    logic     revIn;
    polySel_e poly;
  } modeCfg_t;

  typedef struct packed {
    logic              seedLoad;
    logic              feedByte;
    logic              feedWord;
    logic [WORD_W-1:0] value;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MODE = 2'd1,
    RD_SUM  = 2'd2
  } rdSel_e;

  function automatic logic [WORD_W-1:0] polyTap(input polySel_e sel);
    case (sel)
      POLY_CRC16: polyTap = 32'h0000_8005;
      POLY_CRC32: polyTap = 32'h04C1_1DB7;
      default:    polyTap = 32'h0000_1021;
    endcase
  endfunction

  function automatic logic isWide(input polySel_e sel);
    isWide = (sel == POLY_CRC32);
  endfunction

  function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] v);
    for (int i = 0; i < BYTE_W; i++) rev8[i] = v[BYTE_W-1-i];
  endfunction

  function automatic logic [HALF_W-1:0] rev16(input logic [HALF_W-1:0] v);
    for (int i = 0; i < HALF_W; i++) rev16[i] = v[HALF_W-1-i];
  endfunction

  function automatic logic [WORD_W-1:0] rev32(input logic [WORD_W-1:0] v);
    for (int i = 0; i < WORD_W; i++) rev32[i] = v[WORD_W-1-i];
  endfunction

endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_engine_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busByte,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output modeCfg_t          modeCfg,
  output ctrlStrobe_t       strobe,
  output rdSel_e            rdSel
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFF_SEED);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam int MODE_W = $bits(modeCfg_t);

  logic              modeWr;
  logic              seedWr;
  logic              dataWr;
  logic [BYTE_W-1:0] byteIn;
  logic [WORD_W-1:0] wordIn;

  assign modeWr = busWr && (busAddr == A_MODE);
  assign seedWr = busWr && (busAddr == A_SEED);
  assign dataWr = busWr && (busAddr == A_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeCfg <= '0;
    else if (modeWr) modeCfg <= modeCfg_t'(busWdata[MODE_W-1:0]);
  end

  // input conditioning: optional mirror, then optional inversion
  always_comb begin
    byteIn = modeCfg.revIn ? rev8(busWdata[BYTE_W-1:0]) : busWdata[BYTE_W-1:0];
    wordIn = modeCfg.revIn ? rev32(busWdata) : busWdata;
    if (modeCfg.cmplIn) begin
      byteIn = ~byteIn;
      wordIn = ~wordIn;
    end
  end

  always_comb begin
    strobe.seedLoad = seedWr;
    strobe.feedByte = dataWr && busByte;
    strobe.feedWord = dataWr && !busByte;
    if (seedWr)       strobe.value = busWdata;
    else if (busByte) strobe.value = {byteIn, {(WORD_W-BYTE_W){1'b0}}};
    else              strobe.value = wordIn;
  end

  always_comb begin
    if (busAddr == A_MODE)      rdSel = RD_MODE;
    else if (busAddr == A_DATA) rdSel = RD_SUM;
    else                        rdSel = RD_NONE;
  end

  p_mode_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (modeCfg == $past(busWdata[MODE_W-1:0])));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !modeWr |=> $stable(modeCfg));

  p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.feedByte |-> (strobe.value[WORD_W-BYTE_W-1:0] == '0));

endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_engine_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED_RST = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  modeCfg_t          modeCfg,
  input  ctrlStrobe_t       strobe,
  output logic [WORD_W-1:0] sumOut
);

  localparam logic [WORD_W-1:0] HALF_MASK = {{(WORD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [WORD_W-1:0] crcState;
  logic [WORD_W-1:0] crcNext;
  logic [WORD_W-1:0] tap;
  logic              wide;
  logic [WORD_W-1:0] laneState [LANES+1];
  logic [WORD_W-1:0] rawView;
  logic [WORD_W-1:0] revView;

  assign tap  = polyTap(modeCfg.poly);
  assign wide = isWide(modeCfg.poly);

  function automatic logic [WORD_W-1:0] stepBit(
    input logic [WORD_W-1:0] s, input logic b,
    input logic [WORD_W-1:0] t, input logic w);
    logic fb;
    logic [WORD_W-1:0] n;
    fb = (w ? s[WORD_W-1] : s[HALF_W-1]) ^ b;
    n  = s << 1;
    if (!w) n = n & HALF_MASK;
    if (fb) n = n ^ t;
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] stepByte(
    input logic [WORD_W-1:0] s, input logic [BYTE_W-1:0] d,
    input logic [WORD_W-1:0] t, input logic w);
    logic [WORD_W-1:0] acc;
    acc = s;
    for (int i = BYTE_W-1; i >= 0; i--) acc = stepBit(acc, d[i], t, w);
    return acc;
  endfunction

  // chained byte lanes, most significant lane first
  assign laneState[0] = crcState;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneState[k+1] = stepByte(laneState[k],
                                     strobe.value[WORD_W-1-BYTE_W*k -: BYTE_W], tap, wide);
  end

  always_comb begin
    crcNext = crcState;
    if (strobe.seedLoad)      crcNext = wide ? strobe.value : (strobe.value & HALF_MASK);
    else if (strobe.feedWord) crcNext = laneState[LANES];
    else if (strobe.feedByte) crcNext = laneState[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crcState <= SEED_RST;
    else       crcState <= crcNext;
  end

  // read-path conditioning only; state is never rewritten here
  always_comb begin
    rawView = wide ? crcState : (crcState & HALF_MASK);
    if (!modeCfg.revSum)  revView = rawView;
    else if (wide)        revView = rev32(rawView);
    else                  revView = {{(WORD_W-HALF_W){1'b0}}, rev16(rawView[HALF_W-1:0])};
    sumOut = modeCfg.cmplSum ? (revView ^ (wide ? '1 : HALF_MASK)) : revView;
  end

  p_state_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.seedLoad || strobe.feedByte || strobe.feedWord) |=> $stable(crcState));

  p_seed_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seedLoad |=> (crcState == ($past(wide) ? $past(strobe.value)
                                                  : ($past(strobe.value) & HALF_MASK))));

  p_one_op_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.seedLoad, strobe.feedByte, strobe.feedWord}));

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wide |-> (sumOut[WORD_W-1:HALF_W] == '0));

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_engine_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [WORD_W-1:0] SEED_RST = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busByte,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);

  modeCfg_t          modeCfg;
  ctrlStrobe_t       strobe;
  rdSel_e            rdSel;
  logic [WORD_W-1:0] sumOut;

  crc_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busByte  (busByte),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .modeCfg  (modeCfg),
    .strobe   (strobe),
    .rdSel    (rdSel)
  );

  crc_datapath #(.SEED_RST(SEED_RST)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .modeCfg (modeCfg),
    .strobe  (strobe),
    .sumOut  (sumOut)
  );

  always_comb begin
    case (rdSel)
      RD_MODE: busRdata = {{(WORD_W-$bits(modeCfg_t)){1'b0}}, modeCfg};
      RD_SUM:  busRdata = sumOut;
      default: busRdata = '0;
    endcase
  end

endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busByte = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int checks = 0;
  int failures = 0;
  logic sampleReq = 1'b0;
  logic [31:0] expQ [$];
  string tagQ [$];
  logic [31:0] curExp;
  string curTag;

  always #4 clk = ~clk;   // 125 MHz

  crc_engine dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busByte(busByte),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (sampleReq && expQ.size() != 0) begin
      curExp = expQ.pop_front();
      curTag = tagQ.pop_front();
      checks++;
      if (busRdata !== curExp) begin
        failures++;
        $display("FAIL %s: got %h expected %h", curTag, busRdata, curExp);
      end
    end
  end

  // bench model from the requirements
  function automatic logic [31:0] mByte(logic [31:0] s, logic [7:0] b, int poly);
    logic [31:0] p;
    int top;
    logic fb;
    p = (poly == 2) ? 32'h04C11DB7 : (poly == 1) ? 32'h00008005 : 32'h00001021;
    top = (poly == 2) ? 31 : 15;
    for (int i = 7; i >= 0; i--) begin
      fb = s[top] ^ b[i];
      s = s << 1;
      if (poly != 2) s[31:16] = '0;
      if (fb) s = s ^ p;
    end
    return s;
  endfunction

  function automatic logic [31:0] mRev32(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d, input logic isByte);
    @(posedge clk); #1;
    sampleReq = 1'b0;
    busWr = 1'b1; busAddr = a; busWdata = d; busByte = isByte;
  endtask

  task automatic readCheck(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    busWr = 1'b0; busAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    sampleReq = 1'b1;
  endtask

  task automatic peekSum(output logic [31:0] v);
    @(posedge clk); #1;
    busWr = 1'b0; busAddr = 4'h8; sampleReq = 1'b0;
    @(negedge clk);
    v = busRdata;
  endtask

  task automatic feedStr(input string s);
    for (int i = 0; i < s.len(); i++) busWrite(4'h8, {24'h0, s[i]}, 1'b1);
  endtask

  task automatic finishRun();
    @(posedge clk); #1; sampleReq = 1'b0; busWr = 1'b0;
    @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] raw;
    logic [31:0] m;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    readCheck(4'h0, 32'h0, "R1 mode after reset");
    readCheck(4'h8, 32'h0000FFFF, "R1 sum after reset");

    // R4 R5 CCITT on bytes
    feedStr("123456789");
    readCheck(4'h8, 32'h000029B1, "R4 R5 ccitt check");

    // R12 back-to-back, result visible next cycle
    busWrite(4'h4, 32'hFFFF, 1'b0);
    busWrite(4'h8, 32'hFFFFFF31, 1'b1);  // R5 upper bits ignored
    m = mByte(32'hFFFF, 8'h31, 0);
    readCheck(4'h8, m, "R12 R5 single byte next cycle");
    busWrite(4'h8, 32'h32333435, 1'b0);
    busWrite(4'h8, 32'h36, 1'b1);
    m = mByte(mByte(mByte(mByte(mByte(m, 8'h32, 0), 8'h33, 0), 8'h34, 0), 8'h35, 0), 8'h36, 0);
    readCheck(4'h8, m, "R12 R6 word then byte consecutive");

    // R6 mixed word and byte
    busWrite(4'h4, 32'hFFFF, 1'b0);
    busWrite(4'h8, 32'h31323334, 1'b0);
    busWrite(4'h8, 32'h35363738, 1'b0);
    busWrite(4'h8, 32'h39, 1'b1);
    readCheck(4'h8, 32'h000029B1, "R6 mixed word byte");

    // R2 mode readback
    busWrite(4'h0, 32'h3F, 1'b0);
    readCheck(4'h0, 32'h3F, "R2 mode all bits");
    busWrite(4'h0, 32'hFFFFFFC1, 1'b0);
    readCheck(4'h0, 32'h01, "R2 mode upper ignored");

    // R4 CRC-16 0x8005
    busWrite(4'h4, 32'h0, 1'b0);
    feedStr("123456789");
    readCheck(4'h8, 32'h0000FEE8, "R4 crc16 check");

    // R4 CRC-32 non-reflected with sum complement
    busWrite(4'h0, 32'h22, 1'b0);
    busWrite(4'h4, 32'hFFFFFFFF, 1'b0);
    feedStr("123456789");
    readCheck(4'h8, 32'hFC891918, "R4 crc32 check");

    // R7 reflected CRC-32 on bytes
    busWrite(4'h0, 32'h36, 1'b0);
    busWrite(4'h4, 32'hFFFFFFFF, 1'b0);
    feedStr("123456789");
    readCheck(4'h8, 32'hCBF43926, "R7 reflected crc32 bytes");

    // R7 word reverse across 32 bits
    busWrite(4'h4, 32'hFFFFFFFF, 1'b0);
    busWrite(4'h8, 32'h34333231, 1'b0);
    busWrite(4'h8, 32'h38373635, 1'b0);
    busWrite(4'h8, 32'h39, 1'b1);
    readCheck(4'h8, 32'hCBF43926, "R7 reflected crc32 words");

    // R7 reflected 16-bit
    busWrite(4'h0, 32'h15, 1'b0);
    busWrite(4'h4, 32'h0, 1'b0);
    feedStr("123456789");
    readCheck(4'h8, 32'h0000BB3D, "R7 reflected crc16");

    // R8 input complement, bytes and words
    busWrite(4'h0, 32'h08, 1'b0);
    busWrite(4'h4, 32'hFFFF, 1'b0);
    busWrite(4'h8, 32'hCECDCCCB, 1'b0);
    busWrite(4'h8, 32'hCAC9C8C7, 1'b0);
    busWrite(4'h8, 32'hC6, 1'b1);
    readCheck(4'h8, 32'h000029B1, "R8 complemented input");

    // R9 R11 save, inspect, resume on CRC-32
    busWrite(4'h0, 32'h22, 1'b0);
    busWrite(4'h4, 32'hFFFFFFFF, 1'b0);
    feedStr("12345");
    m = 32'hFFFFFFFF;
    m = mByte(m, 8'h31, 2); m = mByte(m, 8'h32, 2); m = mByte(m, 8'h33, 2);
    m = mByte(m, 8'h34, 2); m = mByte(m, 8'h35, 2);
    readCheck(4'h8, ~m, "R9 sum complement view");
    busWrite(4'h0, 32'h12, 1'b0);
    readCheck(4'h8, mRev32(m), "R9 sum reverse view after mode write");
    busWrite(4'h0, 32'h02, 1'b0);
    peekSum(raw);
    checks++;
    if (raw !== m) begin
      failures++;
      $display("FAIL R11 raw view: got %h expected %h", raw, m);
    end
    busWrite(4'h4, 32'h12345678, 1'b0);
    busWrite(4'h0, 32'h22, 1'b0);
    busWrite(4'h4, raw, 1'b0);
    feedStr("6789");
    readCheck(4'h8, 32'hFC891918, "R11 resume after reseed");

    // R10 16-bit output conditioning, R3 seed masking
    busWrite(4'h0, 32'h30, 1'b0);
    busWrite(4'h4, 32'h0000ABCD, 1'b0);
    readCheck(4'h8, 32'h00004C2A, "R10 R9 16-bit reverse complement");
    busWrite(4'h0, 32'h00, 1'b0);
    busWrite(4'h4, 32'hDEAD1234, 1'b0);
    readCheck(4'h8, 32'h00001234, "R3 R10 seed masked to 16 bits");

    // R3 non-readable offsets
    readCheck(4'h4, 32'h0, "R3 seed offset reads zero");
    readCheck(4'hC, 32'h0, "R3 unmapped reads zero");

    finishRun();
  end

endmodule